// File: doc/BRIEF.md
# Machine-Cycle State Sequencer with Timed Port and Event Counter

This block divides the core clock into a repeating machine cycle of six states, S1 to S6, each state two clocks long (phase 1, then phase 2). From that position it produces single-clock strobes for the rest of a small controller: opcode fetch twice per cycle, a strobe that captures interrupt requests, and a strobe that samples the external event input. Every side effect inside the block is tied to a fixed point in the cycle, not to whichever clock edge a request arrives on.

Two timed datapaths hang off the sequencer. The first is an output port. A write can arrive at any clock. It is held until the end of S6 phase 1, when it loads the port latch. The pin driver copies the latch only on entry to S1. Any pin bit that rises in a cycle gets a strong-pullup enable for the whole of that S1. The second is an event counter. It samples the event input at the end of S5 phase 2. When it sees a high sample followed by a low sample, it adds one to the count at the end of S3 phase 1 of the following cycle. Interrupt request inputs are copied into a flag register at the end of S5 phase 2.

Top module: `mcyc_timing`

## Requirements
- R1: The state index (0 = S1 … 5 = S6) advances by one, wrapping 5 to 0, on every second clock. `phase` is 0 in the first clock of a state and 1 in the second.
- R2: `cycle_start` is high exactly in S1 phase 1.
- R3: `fetch_stb` is high exactly in S1 phase 2 and in S4 phase 2.
- R4: `irq_stb` and `samp_stb` are high exactly in S5 phase 2. `irq_flags` takes `irq_in` at the end of that clock and does not change at any other time.
- R5: The port latch loads at the end of S6 phase 1. It takes the newest write (`wr_en` high) made since the previous load, and a write in that same clock wins. With no write, the latch keeps its value.
- R6: `pin_out` changes only on entry to S1, and then takes the latch value.
- R7: A `boost` bit is 1 throughout S1, both clocks, in the cycle where the matching `pin_out` bit went from 0 to 1. It is 0 at every other time.
- R8: The event input is sampled at the end of S5 phase 2. A sample of 1 followed by a sample of 0 in the next cycle, with `cnt_en` high at the second sample, raises `count` by one (wrapping) at the end of S3 phase 1 of the following cycle.
- R9: While `cnt_en` is low at the second sample, that falling pattern does not change `count`.
- R10: Synchronous active-low reset gives S1 phase 1, latch and `pin_out` all ones, `boost` 0, `count` 0, `irq_flags` 0, and no pending write or event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Port write request |
| wr_data | input | PORT_W | Port write value |
| ev_in | input | 1 | External event input |
| cnt_en | input | 1 | Counter mode enable |
| irq_in | input | IRQ_W | Interrupt request lines |
| state_idx | output | 3 | Current state, 0 = S1 … 5 = S6 |
| phase | output | 1 | 0 = first clock of a state, 1 = second |
| cycle_start | output | 1 | High in S1 phase 1 |
| fetch_stb | output | 1 | Opcode fetch strobe |
| irq_stb | output | 1 | Interrupt capture strobe |
| samp_stb | output | 1 | Event sample strobe |
| pin_out | output | PORT_W | Port pin driver value |
| boost | output | PORT_W | Strong-pullup enable per bit |
| count | output | CNT_W | Event count |
| irq_flags | output | IRQ_W | Captured interrupt flags |

## Verification
The bench builds the block with PORT_W = 4, CNT_W = 4 and IRQ_W = 2. The narrow count wraps after sixteen events, about four hundred clocks, so the wrap from 15 to 0 falls inside the run. A four-bit port makes every bit take both 0-to-1 and 1-to-0 changes many times, both under random writes and under a forced alternation of all-zeros and all-ones. The run also drives bursts of several writes inside one cycle, a stretch with `cnt_en` low, and a reset pulse in the middle of the run.

// File: rtl/mcyc_pkg.sv
// Package: shared state encoding and helpers for the machine-cycle sequencer.
// Assumes six states per machine cycle and two clocks per state.
package mcyc_pkg;

    localparam int NUM_STATES = 6;
    localparam int STATE_W    = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_S1 = 3'd0,
        ST_S2 = 3'd1,
        ST_S3 = 3'd2,
        ST_S4 = 3'd3,
        ST_S5 = 3'd4,
        ST_S6 = 3'd5
    } mcyc_state_e;

    // Successor state in the repeating cycle.
    function automatic mcyc_state_e next_state(input mcyc_state_e cur);
        mcyc_state_e nxt;
        case (cur)
            ST_S1:   nxt = ST_S2;
            ST_S2:   nxt = ST_S3;
            ST_S3:   nxt = ST_S4;
            ST_S4:   nxt = ST_S5;
            ST_S5:   nxt = ST_S6;
            default: nxt = ST_S1;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/mcyc_seq.sv
// Module: mcyc_seq
// Keeps the machine-cycle position (state and phase). Decodes from it the
// external strobes and the internal ticks that time the datapaths.
// Assumes: every strobe and tick lasts one clock. Ticks are mutually exclusive.
module mcyc_seq
    import mcyc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    output mcyc_state_e st,
    output logic        ph,
    output logic        cyc_start,
    output logic        fetch,
    output logic        irq_cap,
    output logic        ev_samp,
    output logic        load_tick,
    output logic        show_tick,
    output logic        boost_clr,
    output logic        inc_tick
);

    // Advance the phase each clock, and the state after phase 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_S1;
            ph <= 1'b0;
        end else if (ph) begin
            st <= next_state(st);
            ph <= 1'b0;
        end else begin
            ph <= 1'b1;
        end
    end

    // Decode the strobes and ticks from the current position.
    always_comb begin
        cyc_start = (st == ST_S1) && !ph;
        fetch     = ((st == ST_S1) || (st == ST_S4)) && ph;
        irq_cap   = (st == ST_S5) && ph;
        ev_samp   = (st == ST_S5) && ph;
        load_tick = (st == ST_S6) && !ph;
        show_tick = (st == ST_S6) && ph;
        boost_clr = (st == ST_S1) && ph;
        inc_tick  = (st == ST_S3) && !ph;
    end

endmodule

// File: rtl/mcyc_port.sv
// Module: mcyc_port
// Output port with a pending-write register, a latch loaded once per cycle,
// a pin buffer refreshed on entry to S1, and per-bit strong-pullup pulses.
// Assumes: load_tick precedes show_tick by one clock, and boost_clr comes two
// clocks after show_tick.
module mcyc_port #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_tick,
    input  logic              show_tick,
    input  logic              boost_clr,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] boost
);

    logic              pend_v;
    logic [PORT_W-1:0] pend_d;
    logic [PORT_W-1:0] latch_q;

    // Hold the newest write until the latch load point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            pend_d <= '1;
        end else if (load_tick) begin
            pend_v <= 1'b0;
        end else if (wr_en) begin
            pend_v <= 1'b1;
            pend_d <= wr_data;
        end
    end

    // Load the port latch once per cycle, at the end of S6 phase 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
        end else if (load_tick) begin
            if (wr_en) begin
                latch_q <= wr_data;
            end else if (pend_v) begin
                latch_q <= pend_d;
            end
        end
    end

    // Per-bit pin buffer and pullup pulse.
    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        // Refresh the pin on entry to S1.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pin_out[b] <= 1'b1;
            end else if (show_tick) begin
                pin_out[b] <= latch_q[b];
            end
        end

        // Raise the pullup for the S1 that follows a 0-to-1 pin change.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                boost[b] <= 1'b0;
            end else if (show_tick) begin
                boost[b] <= latch_q[b] & ~pin_out[b];
            end else if (boost_clr) begin
                boost[b] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mcyc_evcnt.sv
// Module: mcyc_evcnt
// Event counter. Samples the input once per cycle and detects a 1-then-0
// pair of samples. The count rises at a later, fixed tick.
// Assumes: samp_tick and inc_tick never fall in the same clock, and inc_tick
// comes after samp_tick within the next cycle.
module mcyc_evcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_tick,
    input  logic             inc_tick,
    input  logic             cnt_en,
    input  logic             ev_in,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic samp_q;
    logic ev_pend;

    // Capture the sample and note a qualifying falling pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q  <= 1'b0;
            ev_pend <= 1'b0;
        end else if (samp_tick) begin
            samp_q  <= ev_in;
            ev_pend <= cnt_en & samp_q & ~ev_in;
        end else if (inc_tick) begin
            ev_pend <= 1'b0;
        end
    end

    // Apply a pending event to the count at the increment tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc_tick && ev_pend) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/mcyc_timing.sv
// Module: mcyc_timing (top)
// Machine-cycle sequencer with timed port, event counter and interrupt capture.
// Assumes: one clock domain and a synchronous active-low reset held for at
// least one clock.
module mcyc_timing
    import mcyc_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int CNT_W  = 16,
    parameter int IRQ_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              ev_in,
    input  logic              cnt_en,
    input  logic [IRQ_W-1:0]  irq_in,
    output logic [2:0]        state_idx,
    output logic              phase,
    output logic              cycle_start,
    output logic              fetch_stb,
    output logic              irq_stb,
    output logic              samp_stb,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] boost,
    output logic [CNT_W-1:0]  count,
    output logic [IRQ_W-1:0]  irq_flags
);

    mcyc_state_e st;
    logic        load_tick;
    logic        show_tick;
    logic        boost_clr;
    logic        inc_tick;

    mcyc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (st),
        .ph        (phase),
        .cyc_start (cycle_start),
        .fetch     (fetch_stb),
        .irq_cap   (irq_stb),
        .ev_samp   (samp_stb),
        .load_tick (load_tick),
        .show_tick (show_tick),
        .boost_clr (boost_clr),
        .inc_tick  (inc_tick)
    );

    assign state_idx = st;

    mcyc_port #(.PORT_W(PORT_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_tick (load_tick),
        .show_tick (show_tick),
        .boost_clr (boost_clr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .pin_out   (pin_out),
        .boost     (boost)
    );

    mcyc_evcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_tick (samp_stb),
        .inc_tick  (inc_tick),
        .cnt_en    (cnt_en),
        .ev_in     (ev_in),
        .count     (count)
    );

    // Capture the interrupt request lines at the capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flags <= '0;
        end else if (irq_stb) begin
            irq_flags <= irq_in;
        end
    end

endmodule

// File: rtl/mcyc_timing_chk.sv
// Module: mcyc_timing_chk
// Timing properties of mcyc_timing, bound to every instance of it.
module mcyc_timing_chk #(
    parameter int PORT_W = 8,
    parameter int CNT_W  = 16,
    parameter int IRQ_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        state_idx,
    input logic              phase,
    input logic              fetch_stb,
    input logic              samp_stb,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] boost,
    input logic [CNT_W-1:0]  count,
    input logic [IRQ_W-1:0]  irq_flags
);

    // R1
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> (state_idx == $past(state_idx)));

    // R3
    fetch_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |-> phase);

    // R4
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_idx == 3'd5 && !phase) |-> $stable(irq_flags));

    // R6
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_idx == 3'd0 && !phase) |-> $stable(pin_out));

    // R7
    boost_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|boost) |-> (state_idx == 3'd0));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (state_idx == 3'd2 && phase));

    // R4
    samp_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |-> (state_idx == 3'd4));

endmodule

bind mcyc_timing mcyc_timing_chk #(
    .PORT_W (PORT_W),
    .CNT_W  (CNT_W),
    .IRQ_W  (IRQ_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_idx (state_idx),
    .phase     (phase),
    .fetch_stb (fetch_stb),
    .samp_stb  (samp_stb),
    .pin_out   (pin_out),
    .boost     (boost),
    .count     (count),
    .irq_flags (irq_flags)
);

// File: tb/test_mcyc_timing.sv
// Bench: a behavioural model stepped by a position counter, compared with the
// block on every falling edge.
module test_mcyc_timing;

    localparam int PW = 4;
    localparam int CW = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [PW-1:0] wr_data = '0;
    logic          ev_in = 1'b0;
    logic          cnt_en = 1'b1;
    logic [IW-1:0] irq_in = '0;
    logic [2:0]    state_idx;
    logic          phase, cycle_start, fetch_stb, irq_stb, samp_stb;
    logic [PW-1:0] pin_out, boost;
    logic [CW-1:0] count;
    logic [IW-1:0] irq_flags;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mcyc_timing #(.PORT_W(PW), .CNT_W(CW), .IRQ_W(IW)) i_mcyc_timing (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ev_in(ev_in), .cnt_en(cnt_en), .irq_in(irq_in),
        .state_idx(state_idx), .phase(phase), .cycle_start(cycle_start),
        .fetch_stb(fetch_stb), .irq_stb(irq_stb), .samp_stb(samp_stb),
        .pin_out(pin_out), .boost(boost), .count(count), .irq_flags(irq_flags)
    );

    // Reference model state: pos runs 0..11 across the machine cycle.
    int      pos = 0;
    bit      seen = 0;
    int      m_latch, m_pin, m_boost, m_pend_d, m_irq, m_count;
    bit      m_pend, m_samp, m_evp;

    always @(posedge clk) begin
        seen = 1;
        if (!rst_n) begin
            pos = 0; m_latch = (1 << PW) - 1; m_pin = m_latch; m_boost = 0;
            m_pend = 0; m_pend_d = 0; m_irq = 0; m_count = 0;
            m_samp = 0; m_evp = 0;
        end else begin
            // R5: latch load with pending or simultaneous write
            if (pos == 10) begin
                if (wr_en) m_latch = int'(wr_data);
                else if (m_pend) m_latch = m_pend_d;
                m_pend = 0;
            end else if (wr_en) begin
                m_pend = 1; m_pend_d = int'(wr_data);
            end
            // R6, R7: pin refresh and boost on entry to S1
            if (pos == 11) begin
                m_boost = m_latch & ~m_pin;
                m_pin = m_latch;
            end
            if (pos == 1) m_boost = 0;
            // R4, R8, R9: capture and sampling at end of S5 phase 2
            if (pos == 9) begin
                m_irq = int'(irq_in);
                m_evp = cnt_en && m_samp && !ev_in;
                m_samp = ev_in;
            end
            if (pos == 4 && m_evp) begin
                m_count = (m_count + 1) % (1 << CW);
                m_evp = 0;
            end
            pos = (pos + 1) % 12;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 state", int'(state_idx), pos / 2);
        chk("R1 phase", int'(phase), pos % 2);
        chk("R2 cycle_start", int'(cycle_start), int'(pos == 0));
        chk("R3 fetch", int'(fetch_stb), int'(pos == 1 || pos == 7));
        chk("R4 irq_stb", int'(irq_stb), int'(pos == 9));
        chk("R4 samp_stb", int'(samp_stb), int'(pos == 9));
        chk("R4 irq_flags", int'(irq_flags), m_irq);
        chk("R6 pin_out", int'(pin_out), m_pin);
        chk("R7 boost", int'(boost), m_boost);
        chk("R8 count", int'(count), m_count);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R10: reset state after synchronous reset edges
        chk("R10 state", int'(state_idx), 0);
        chk("R10 pin", int'(pin_out), (1 << PW) - 1);
        chk("R10 count", int'(count), 0);
        chk("R10 boost", int'(boost), 0);
        chk("R10 flags", int'(irq_flags), 0);
        rst_n = 1'b1;
        for (int t = 0; t < 6000; t++) begin
            @(negedge clk);
            if (seen) compare_all();
            irq_in = IW'($urandom);
            if (t < 1200) begin
                // random writes, slow event toggling (R5, R8)
                wr_en   = ($urandom % 5) == 0;
                wr_data = PW'($urandom);
                ev_in   = ((t / 12) % 2) == 1;
            end else if (t < 2400) begin
                // alternate all-zero and all-one writes (R7), bursts (R5)
                wr_en   = (t % 12) < 3;
                wr_data = ((t / 24) % 2) == 1 ? '1 : '0;
                if ((t % 12) == 2) wr_data = PW'($urandom);
                ev_in   = ((t / 36) % 2) == 1;
            end else if (t < 3600) begin
                // counter disabled: falling pairs must not count (R9)
                cnt_en  = (t < 3000) ? 1'b0 : 1'b1;
                wr_en   = ($urandom % 9) == 0;
                wr_data = PW'($urandom);
                ev_in   = ((t / 12) % 2) == 1;
            end else if (t < 3610) begin
                // mid-run reset (R10)
                rst_n   = (t < 3605) ? 1'b0 : 1'b1;
                wr_en   = 1'b1;
                wr_data = '0;
            end else begin
                cnt_en  = 1'b1;
                wr_en   = ($urandom % 3) == 0;
                wr_data = PW'($urandom);
                ev_in   = ($urandom % 2) == 1;
            end
        end
        finish_run();
    end

endmodule